// File: doc/BRIEF.md
# TLB Support Register Access Unit

This block holds the support-register file that software uses to manage a translation lookaside buffer by hand. A processor core moves a general register into a support register, or reads a support register back, through a simple one-access-per-cycle port. Four banks of sixteen registers exist. The bank in use comes from the low two bits of a bank-select word driven by the core.

Two of the banks are MMU banks, and each owns its own small TLB array. In those banks, some register indices have side effects. Writing the TLB-hi register also updates the MMU cause register. Writing the TLB-lo register commits a whole entry: the written value becomes the entry's lo word, and the value already held in the cause register becomes its hi word. Reading any register in an MMU bank first reloads the TLB-hi and TLB-lo mirror registers from the entry that the select register points at.

When an entry is replaced, the block emits a one-cycle invalidate strobe with the page-aligned virtual address of the entry's previous contents. A downstream translation cache uses that strobe to drop the stale page.

Top module: `tlbSregUnit`

## Requirements
- R1: The active bank is `bankSelRaw[1:0]`. Bits 31:2 of `bankSelRaw` have no effect on any read, write or strobe.
- R2: A write stores `wrData` into register `regIdx` of the active bank. While `rdEn` is high, `rdData` combinationally returns the stored value, except for the mirror indices 5 and 6 in banks 1 and 2.
- R3: In bank 1 or 2, a write to index 6 (TLB-hi) also writes the same value into index 3 (MMU cause) of that bank. In banks 0 and 3, index 6 is an ordinary register and index 3 is left unchanged.
- R4: In bank 1 or 2, a write to index 5 (TLB-lo) commits one entry of that bank's own array, called slot (bank-1). The lo word is `wrData` and the hi word is the bank's cause register. The set comes from bits 5:4 of the select register (index 4) and the entry from bits 3:0. Higher select bits are ignored.
- R5: On a commit, `invValid` is high for exactly the one cycle after the write edge. `invAddr` then carries the hi word the entry held before the commit, with bits 12:0 cleared.
- R6: Writes in banks 0 and 3, and writes to any index other than 5, never raise `invValid` and never change a TLB entry.
- R7: A read in bank 1 or 2 of index 6 or 5 returns the selected entry's hi or lo word in the same cycle. On the clock edge, the block copies both words into that bank's mirror registers.
- R8: After reset, all registers, all TLB entries and `invValid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write the addressed support register this cycle |
| rdEn | input | 1 | Read the addressed support register this cycle |
| bankSelRaw | input | 32 | Bank-select word; only bits 1:0 are used |
| regIdx | input | 4 | Support-register index within the bank |
| wrData | input | 32 | Value to write |
| rdData | output | 32 | Combinational read value, valid while rdEn is high |
| invValid | output | 1 | One-cycle page-invalidate strobe |
| invAddr | output | 32 | Page-aligned virtual address to invalidate |

## Verification
The properties assume that `wrEn` and `rdEn` are never high in the same cycle. They also assume that a read which follows a write to the same location comes in the very next cycle, with no other access in between. The stimulus issues exactly one access per cycle and never raises both enables together. The sweeps write every index of every bank and commit every entry of both MMU arrays twice. The select words in the sweeps carry junk in their upper bits, so the ignored bits are exercised throughout.

// File: rtl/tlbSregPkg.sv
package tlbSregPkg;

  localparam int BANK_W    = 2;
  localparam int REG_IDX_W = 4;
  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int NUM_REGS  = 1 << REG_IDX_W;

  localparam logic [REG_IDX_W-1:0] CAUSE_IDX = 4'd3;
  localparam logic [REG_IDX_W-1:0] SEL_IDX   = 4'd4;
  localparam logic [REG_IDX_W-1:0] LO_IDX    = 4'd5;
  localparam logic [REG_IDX_W-1:0] HI_IDX    = 4'd6;

  typedef struct packed {
    logic                 regWr;
    logic                 causeWr;
    logic                 commit;
    logic                 reload;
    logic                 slot;
    logic [BANK_W-1:0]    bank;
    logic [REG_IDX_W-1:0] idx;
  } sregStrobe_t;

endpackage

// File: rtl/tlbSregCtrl.sv
module tlbSregCtrl
  import tlbSregPkg::*;
(
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [BANK_W-1:0]    bankSel,
  input  logic [REG_IDX_W-1:0] regIdx,
  output sregStrobe_t          strobe
);

  logic mmuBank;

  // Only banks 1 and 2 carry TLB side effects.
  assign mmuBank = (bankSel == 2'd1) || (bankSel == 2'd2);

  always_comb begin
    strobe         = '0;
    strobe.bank    = bankSel;
    strobe.idx     = regIdx;
    strobe.slot    = (bankSel == 2'd2);
    strobe.regWr   = wrEn;
    strobe.causeWr = wrEn && mmuBank && (regIdx == HI_IDX);
    strobe.commit  = wrEn && mmuBank && (regIdx == LO_IDX);
    strobe.reload  = rdEn && !wrEn && mmuBank;
  end

endmodule

// File: rtl/tlbSregDatapath.sv
module tlbSregDatapath
  import tlbSregPkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int SETS       = 4,
  parameter int ENTRIES    = 16,
  parameter int PAGE_SHIFT = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  sregStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              invValid,
  output logic [DATA_W-1:0] invAddr
);

  localparam int SET_W   = $clog2(SETS);
  localparam int ENT_W   = $clog2(ENTRIES);
  localparam int SEL_W   = SET_W + ENT_W;
  localparam int ADDR_W  = SEL_W + 1;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int REG_CNT = NUM_BANKS * NUM_REGS;
  localparam logic [DATA_W-1:0] PAGE_MASK = {DATA_W{1'b1}} << PAGE_SHIFT;

  logic [DATA_W-1:0] regFile [REG_CNT];
  logic [DATA_W-1:0] tlbHi   [DEPTH];
  logic [DATA_W-1:0] tlbLo   [DEPTH];

  logic [SEL_W-1:0]  selField;
  logic [ADDR_W-1:0] entAddr;
  logic [DATA_W-1:0] curHi;
  logic [DATA_W-1:0] curLo;
  logic [DATA_W-1:0] causeCur;

  // Set in the upper part of the select field, entry in the lower part.
  assign selField = regFile[{strobe.bank, SEL_IDX}][SEL_W-1:0];
  assign entAddr  = {strobe.slot, selField};
  assign curHi    = tlbHi[entAddr];
  assign curLo    = tlbLo[entAddr];
  assign causeCur = regFile[{strobe.bank, CAUSE_IDX}];

  // A read in an MMU bank sees the entry words in place of the mirrors.
  always_comb begin
    if (strobe.reload && strobe.idx == HI_IDX)
      rdData = curHi;
    else if (strobe.reload && strobe.idx == LO_IDX)
      rdData = curLo;
    else
      rdData = regFile[{strobe.bank, strobe.idx}];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_CNT; i++) regFile[i] <= '0;
      for (int j = 0; j < DEPTH; j++) begin
        tlbHi[j] <= '0;
        tlbLo[j] <= '0;
      end
      invValid <= 1'b0;
      invAddr  <= '0;
    end else begin
      invValid <= 1'b0;
      if (strobe.regWr)
        regFile[{strobe.bank, strobe.idx}] <= wrData;
      if (strobe.causeWr)
        regFile[{strobe.bank, CAUSE_IDX}] <= wrData;
      if (strobe.commit) begin
        invValid       <= 1'b1;
        invAddr        <= curHi & PAGE_MASK;
        tlbLo[entAddr] <= wrData;
        tlbHi[entAddr] <= causeCur;
      end
      if (strobe.reload) begin
        regFile[{strobe.bank, HI_IDX}] <= curHi;
        regFile[{strobe.bank, LO_IDX}] <= curLo;
      end
    end
  end

endmodule

// File: rtl/tlbSregUnit.sv
module tlbSregUnit
  import tlbSregPkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int SETS       = 4,
  parameter int ENTRIES    = 16,
  parameter int PAGE_SHIFT = 13
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [DATA_W-1:0]    bankSelRaw,
  input  logic [REG_IDX_W-1:0] regIdx,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic                 invValid,
  output logic [DATA_W-1:0]    invAddr
);

  sregStrobe_t strobe;
  logic        unusedSelBits;

  assign unusedSelBits = ^bankSelRaw[DATA_W-1:BANK_W];

  tlbSregCtrl u_ctrl (
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .bankSel (bankSelRaw[BANK_W-1:0]),
    .regIdx  (regIdx),
    .strobe  (strobe)
  );

  tlbSregDatapath #(
    .DATA_W     (DATA_W),
    .SETS       (SETS),
    .ENTRIES    (ENTRIES),
    .PAGE_SHIFT (PAGE_SHIFT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .rdData   (rdData),
    .invValid (invValid),
    .invAddr  (invAddr)
  );

endmodule

// File: rtl/tlbSregChecker.sv
module tlbSregChecker #(
  parameter int DATA_W     = 32,
  parameter int PAGE_SHIFT = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [DATA_W-1:0] bankSelRaw,
  input logic [3:0]        regIdx,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              invValid,
  input logic [DATA_W-1:0] invAddr
);

  localparam logic [DATA_W-1:0] LOW_MASK = ~({DATA_W{1'b1}} << PAGE_SHIFT);

  logic [1:0] bank;
  logic       mmu;
  logic       unusedRawBits;

  assign bank          = bankSelRaw[1:0];
  assign mmu           = (bank == 2'd1) || (bank == 2'd2);
  assign unusedRawBits = ^bankSelRaw[DATA_W-1:2];

  // R5: a strobe is always caused by a TLB-lo write in an MMU bank
  assert_inv_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> $past(wrEn && mmu && regIdx == 4'd5));

  // R5: the invalidate address is page aligned
  assert_inv_aligned_R5: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> ((invAddr & LOW_MASK) == '0));

  // R6: plain-bank writes never raise the strobe
  assert_no_inv_plain_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !mmu) |=> !invValid);

  // R2: write then immediate read of the same plain-bank register
  assert_reg_store_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !mmu) |=>
      (!(rdEn && !wrEn && bankSelRaw[1:0] == $past(bank) && regIdx == $past(regIdx))
       || rdData == $past(wrData)));

  // R3: TLB-hi write shows up in the cause register
  assert_cause_copy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && mmu && regIdx == 4'd6) |=>
      (!(rdEn && !wrEn && bankSelRaw[1:0] == $past(bank) && regIdx == 4'd3)
       || rdData == $past(wrData)));

endmodule

bind tlbSregUnit tlbSregChecker #(
  .DATA_W     (DATA_W),
  .PAGE_SHIFT (PAGE_SHIFT)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .rdEn       (rdEn),
  .bankSelRaw (bankSelRaw),
  .regIdx     (regIdx),
  .wrData     (wrData),
  .rdData     (rdData),
  .invValid   (invValid),
  .invAddr    (invAddr)
);

// File: tb/tlbSregUnit_tb.sv
module tlbSregUnit_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] bankSelRaw = '0;
  logic [3:0]  regIdx = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        invValid;
  logic [31:0] invAddr;

  int total = 0;
  int bad = 0;

  logic [31:0] mRegs [64];
  logic [31:0] mHi   [128];
  logic [31:0] mLo   [128];

  always #(CLK_PERIOD/2) clk = ~clk;

  tlbSregUnit u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .bankSelRaw(bankSelRaw), .regIdx(regIdx), .wrData(wrData),
    .rdData(rdData), .invValid(invValid), .invAddr(invAddr)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit isMmu(input int b);
    return (b == 1) || (b == 2);
  endfunction

  function automatic int entryOf(input int b);
    return (b - 1) * 64 + int'(mRegs[b*16 + 4][5:0]);
  endfunction

  task automatic doWrite(input int b, input int idx, input logic [31:0] d, input string tag);
    bit          expV = 0;
    logic [31:0] expA = '0;
    int          a = 0;
    if (isMmu(b) && idx == 5) begin
      a    = entryOf(b);
      expV = 1;
      expA = mHi[a] & 32'hFFFF_E000;
    end
    mRegs[b*16 + idx] = d;
    if (isMmu(b) && idx == 6) mRegs[b*16 + 3] = d;
    if (expV) begin
      mLo[a] = d;
      mHi[a] = mRegs[b*16 + 3];
    end
    @(negedge clk);
    wrEn = 1'b1; rdEn = 1'b0;
    bankSelRaw = 32'hA5A5_A5A4 | 32'(b);
    regIdx = 4'(idx); wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
    check(invValid == expV, {tag, " R5 R6 strobe"}, 32'(invValid), 32'(expV));
    if (expV) check(invAddr == expA, {tag, " R5 address"}, invAddr, expA);
  endtask

  task automatic doRead(input int b, input int idx, input string tag);
    logic [31:0] exp;
    if (isMmu(b)) begin
      mRegs[b*16 + 6] = mHi[entryOf(b)];
      mRegs[b*16 + 5] = mLo[entryOf(b)];
    end
    exp = mRegs[b*16 + idx];
    @(negedge clk);
    rdEn = 1'b1; wrEn = 1'b0;
    bankSelRaw = 32'hFFFF_FFFC | 32'(b);
    regIdx = 4'(idx);
    #1;
    check(rdData == exp, tag, rdData, exp);
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mRegs[i] = '0;
    for (int i = 0; i < 128; i++) begin mHi[i] = '0; mLo[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R8: reset state
    check(invValid == 1'b0, "R8 invValid after reset", 32'(invValid), 0);
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 16; i++) doRead(b, i, "R8 reset read");

    // R1 R2 R3 R6: write every register of every bank, then read back
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 16; i++)
        doWrite(b, i, 32'h1357_0000 + 32'(b*256 + i*17), "R2 sweep write");
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 16; i++) doRead(b, i, "R1 R2 R3 sweep read");

    // R3: cause copy only in MMU banks
    for (int b = 0; b < 4; b++) begin
      doWrite(b, 6, 32'hCAFE_0000 + 32'(b), "R3 hi write");
      doRead(b, 3, "R3 cause after hi write");
    end

    // R4 R5: commit every entry of both arrays twice
    for (int pass = 0; pass < 2; pass++)
      for (int b = 1; b < 3; b++)
        for (int k = 0; k < 64; k++) begin
          doWrite(b, 4, (pass == 1 ? 32'hFFFF_FF00 : 32'h0000_0F00) | 32'(k), "R4 select");
          doWrite(b, 6, 32'h1000_0000 + 32'(pass) * 32'h4000_0000 + 32'(b*64 + k) * 32'h2000 + 32'h0123,
                  "R4 hi");
          doWrite(b, 5, 32'hB00C_0000 + 32'(pass*1024 + b*128 + k), "R4 R5 commit");
        end

    // R4 R7: readback of every entry through the mirrors
    for (int b = 1; b < 3; b++)
      for (int k = 0; k < 64; k++) begin
        doWrite(b, 4, 32'h7700_0000 | 32'(63 - k), "R4 reselect");
        doRead(b, 6, "R7 entry hi");
        doRead(b, 5, "R7 entry lo");
        doRead(b, 0, "R7 other read");
      end

    // R6: TLB-lo index in plain banks is ordinary storage
    for (int b = 0; b < 4; b += 3) begin
      doWrite(b, 5, 32'hDEAD_0000 + 32'(b), "R6 plain lo write");
      doRead(b, 5, "R6 plain lo read");
      doRead(b, 6, "R6 plain hi read");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule